// File: doc/BRIEF.md
# Host Memory Window Access Port

This block gives a 16-bit host I/O bus a window into a coprocessor's private memory. The host sets a 32-bit window address by writing two 16-bit address registers, low half first. It then moves words through data ports. An optional auto-increment mode steps the window after each data access, so a block of memory can be streamed without reloading the address.

Two stores share the window and are told apart by the address alone. Bit 22 clear selects the 16-bit data store, indexed by the window address as written. Bit 22 set selects the 32-bit instruction store. Its word index sits two bits up, so one instruction spans four window units. An instruction word moves as a low-half access followed by a high-half access. The high half uses the same port that carries a whole data-store word. A separate port returns a data-store word and zeroes that location in the same access. Both stores are modelled as register arrays.

Top module: `hmw_port`

## Requirements
- R1: After reset the window address is 0, auto-increment is off (control port reads 0) and `bus_rvalid` is low.
- R2: A write to port 0 loads window address bits 15:0 and a write to port 1 loads bits 31:16. A read of either port returns that half.
- R3: With address bit 22 clear, the data store is indexed by the low log2(DS_DEPTH) bits of the window address, with no translation. With bit 22 set, the instruction store is indexed by address bits starting at bit 2.
- R4: In the data store, port 2 writes and reads one full 16-bit word.
- R5: In the instruction store, a write to port 3 is held in a staging register. A later write to port 2 commits {port 2 data, staged data} as one 32-bit word. Until then the stored word is unchanged. Reads return bits 15:0 on port 3 and bits 31:16 on port 2.
- R6: A read of port 4 with bit 22 clear returns the addressed data-store word and writes zero to it. With bit 22 set it returns 0 and changes neither memory nor address.
- R7: With control bit 0 (port 5) set, each data-store access through port 2 or port 4 advances the window address by 1.
- R8: With auto-increment on, an instruction-store access through port 2 advances the address by 4. An access through port 3 never moves it.
- R9: With control bit 0 clear, data accesses leave the window address unchanged.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. When `bus_wr` and `bus_rd` are both high, only the write takes effect and no read is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_sel | input | 3 | Port select: 0 addr low, 1 addr high, 2 data/high half, 3 instruction low half, 4 read-and-clear, 5 control |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
On every cycle the assertions check how the address moves: +1 for a data-store access, +4 after an instruction high-half access, no movement on a low-half access or with auto-increment off. They also check that a write suppresses a simultaneous read, and that a read-and-clear in the instruction region returns zero without moving the address. Only the bench scenarios can show memory contents. These include aliasing of data-store addresses beyond the array, the staged low half staying invisible until the high half commits, and a cleared location reading back as zero afterwards.

// File: rtl/hmw_pkg.sv
package hmw_pkg;
  typedef enum logic [2:0] {
    PORT_ADDR_LO = 3'd0,
    PORT_ADDR_HI = 3'd1,
    PORT_DATA    = 3'd2,
    PORT_INSN_LO = 3'd3,
    PORT_CLEAR   = 3'd4,
    PORT_CTRL    = 3'd5
  } port_e;

  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned IS_SEL_BIT = 22;
  localparam logic [ADDR_W-1:0] DS_STEP = 32'd1;
  localparam logic [ADDR_W-1:0] IS_STEP = 32'd4;
endpackage

// File: rtl/hmw_ram.sv
module hmw_ram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hmw_addr_ctl.sv
module hmw_addr_ctl
  import hmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic [HALF_W-1:0] wdata,
  input  logic              step_en,
  input  logic              step_wide,
  output logic [ADDR_W-1:0] win_addr,
  output logic              auto_inc
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              inc_q, inc_d;

  always_comb begin
    addr_d = addr_q;
    inc_d  = inc_q;
    if (wr_lo)   addr_d[HALF_W-1:0]      = wdata;
    if (wr_hi)   addr_d[ADDR_W-1:HALF_W] = wdata;
    if (wr_ctrl) inc_d = wdata[0];
    if (step_en && inc_q)
      addr_d = addr_q + (step_wide ? IS_STEP : DS_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      inc_q  <= inc_d;
    end
  end

  assign win_addr = addr_q;
  assign auto_inc = inc_q;

  // R7: data-store access with auto-increment steps by one
  p_ds_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_wide && auto_inc) |=> (win_addr == $past(win_addr) + 32'd1));
  // R8: instruction high-half access steps by four
  p_is_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_wide && auto_inc) |=> (win_addr == $past(win_addr) + 32'd4));
  // R9: no movement with auto-increment off
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !auto_inc && !wr_lo && !wr_hi) |=> $stable(win_addr));
endmodule

// File: rtl/hmw_port.sv
module hmw_port
  import hmw_pkg::*;
#(
  parameter int unsigned DS_DEPTH = 64,
  parameter int unsigned IS_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid
);
  localparam int unsigned DS_AW = $clog2(DS_DEPTH);
  localparam int unsigned IS_AW = $clog2(IS_DEPTH);
  localparam int unsigned IS_W  = 2 * HALF_W;

  port_e             sel;
  logic              wr_cyc, rd_cyc, is_win;
  logic              data_acc, clr_acc, step_en;
  logic [ADDR_W-1:0] win_addr;
  logic              auto_inc;
  logic              ds_we, is_we;
  logic [DS_AW-1:0]  ds_idx;
  logic [IS_AW-1:0]  is_idx;
  logic [HALF_W-1:0] ds_wd, ds_rd;
  logic [IS_W-1:0]   is_wd, is_rd;
  logic [HALF_W-1:0] stage_q, stage_d;
  logic [HALF_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  assign sel      = port_e'(bus_sel);
  assign wr_cyc   = bus_wr;
  assign rd_cyc   = bus_rd && !bus_wr;
  assign is_win   = win_addr[IS_SEL_BIT];
  assign ds_idx   = win_addr[DS_AW-1:0];
  assign is_idx   = win_addr[IS_AW+1:2];

  assign data_acc = (wr_cyc || rd_cyc) && (sel == PORT_DATA);
  assign clr_acc  = rd_cyc && (sel == PORT_CLEAR) && !is_win;
  assign step_en  = data_acc || clr_acc;

  assign ds_we    = (wr_cyc && (sel == PORT_DATA) && !is_win) || clr_acc;
  assign ds_wd    = clr_acc ? '0 : bus_wdata;
  assign is_we    = wr_cyc && (sel == PORT_DATA) && is_win;
  assign is_wd    = {bus_wdata, stage_q};

  hmw_addr_ctl i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_cyc && (sel == PORT_ADDR_LO)),
    .wr_hi     (wr_cyc && (sel == PORT_ADDR_HI)),
    .wr_ctrl   (wr_cyc && (sel == PORT_CTRL)),
    .wdata     (bus_wdata),
    .step_en   (step_en),
    .step_wide (is_win),
    .win_addr  (win_addr),
    .auto_inc  (auto_inc)
  );

  hmw_ram #(.WIDTH(HALF_W), .DEPTH(DS_DEPTH)) i_ds (
    .clk (clk), .we (ds_we), .waddr (ds_idx), .wdata (ds_wd),
    .raddr (ds_idx), .rdata (ds_rd)
  );

  hmw_ram #(.WIDTH(IS_W), .DEPTH(IS_DEPTH)) i_is (
    .clk (clk), .we (is_we), .waddr (is_idx), .wdata (is_wd),
    .raddr (is_idx), .rdata (is_rd)
  );

  always_comb begin
    stage_d = stage_q;
    if (wr_cyc && (sel == PORT_INSN_LO)) stage_d = bus_wdata;
  end

  always_comb begin
    unique case (sel)
      PORT_ADDR_LO: rdata_d = win_addr[HALF_W-1:0];
      PORT_ADDR_HI: rdata_d = win_addr[ADDR_W-1:HALF_W];
      PORT_CTRL:    rdata_d = {{(HALF_W-1){1'b0}}, auto_inc};
      PORT_DATA:    rdata_d = is_win ? is_rd[IS_W-1:HALF_W] : ds_rd;
      PORT_INSN_LO: rdata_d = is_win ? is_rd[HALF_W-1:0] : '0;
      PORT_CLEAR:   rdata_d = is_win ? '0 : ds_rd;
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      if (rd_cyc) rdata_q <= rdata_d;
      rvalid_q <= rd_cyc;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R10: a write in the same cycle suppresses the read
  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> !bus_rvalid);
  // R8: low-half instruction access never moves the window
  p_lo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && (bus_sel == 3'd3)) |=> $stable(win_addr));
  // R6: read-and-clear in the instruction region is inert
  p_clr_is_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && (bus_sel == 3'd4) && is_win)
      |=> (bus_rdata == 16'h0) && $stable(win_addr));
endmodule

// File: tb/test_hmw_port.sv
`timescale 1ns/1ps
module test_hmw_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_sel;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, DAT = 3'd2,
                         ILO = 3'd3, CLR = 3'd4, CTL = 3'd5;

  always #5 clk = ~clk;

  hmw_port i_hmw_port (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_sel (bus_sel), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic get(input logic [2:0] s, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] hi, input logic [15:0] lo);
    put(A_LO, lo);
    put(A_HI, hi);
  endtask

  // monitor: pops expected reads from the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: actual unexpected read %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_sel = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rvalid", {15'd0, bus_rvalid}, 16'h0);
    get(A_LO, 16'h0000, "R1 addr lo");
    get(A_HI, 16'h0000, "R1 addr hi");
    get(CTL,  16'h0000, "R1 ctrl");

    // R2 address halves
    set_addr(16'h1234, 16'h0005);
    get(A_LO, 16'h0005, "R2 lo");
    get(A_HI, 16'h1234, "R2 hi");

    // R9 / R4 data store, auto-increment off
    set_addr(16'h0000, 16'h0003);
    put(DAT, 16'hA5A5);
    get(A_LO, 16'h0003, "R9 after write");
    get(DAT, 16'hA5A5, "R4 readback");
    get(A_LO, 16'h0003, "R9 after read");

    // R3 untranslated index, aliases modulo depth 64
    put(A_LO, 16'h0043);
    get(DAT, 16'hA5A5, "R3 alias");

    // R7 auto-increment streaming
    put(CTL, 16'h0001);
    get(CTL, 16'h0001, "R7 ctrl");
    put(A_LO, 16'h000A);
    put(DAT, 16'h1111); put(DAT, 16'h2222); put(DAT, 16'h3333);
    get(A_LO, 16'h000D, "R7 write step");
    put(A_LO, 16'h000A);
    get(DAT, 16'h1111, "R7 s0"); get(DAT, 16'h2222, "R7 s1"); get(DAT, 16'h3333, "R7 s2");
    get(A_LO, 16'h000D, "R7 read step");

    // R6 read-and-clear in data store
    put(A_LO, 16'h000B);
    get(CLR, 16'h2222, "R6 clear value");
    get(A_LO, 16'h000C, "R7 clear step");
    put(A_LO, 16'h000B);
    get(DAT, 16'h0000, "R6 cleared");

    // R5 / R8 instruction store at index 5
    set_addr(16'h0040, 16'h0014);
    put(ILO, 16'hBEEF);
    get(A_LO, 16'h0014, "R8 low no step");
    put(DAT, 16'hCAFE);
    get(A_LO, 16'h0018, "R8 high step");
    put(A_LO, 16'h0014);
    get(ILO, 16'hBEEF, "R5 low half");
    get(A_LO, 16'h0014, "R8 low read no step");
    get(DAT, 16'hCAFE, "R5 high half");
    put(A_LO, 16'h0014);
    put(ILO, 16'h0001);
    get(ILO, 16'hBEEF, "R5 staged not visible");
    put(DAT, 16'h0002);
    put(A_LO, 16'h0014);
    get(ILO, 16'h0001, "R5 commit low");
    get(DAT, 16'h0002, "R5 commit high");

    // R6 clear in instruction region is inert
    put(A_LO, 16'h0014);
    get(CLR, 16'h0000, "R6 IS clear");
    get(A_LO, 16'h0014, "R6 IS no step");
    get(ILO, 16'h0001, "R6 IS untouched");

    // R10 write wins over simultaneous read
    @(negedge clk);
    bus_sel = A_LO; bus_wdata = 16'h0020; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 no rvalid", {15'd0, bus_rvalid}, 16'h0);
    get(A_LO, 16'h0020, "R10 write took");

    repeat (3) @(negedge clk);
    check("R10 all reads returned", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule